// File: doc/BRIEF.md
# Multi-Bank Divided Clock Network

This block turns one stream of source clock ticks into three banks of divided clocks and one feedback clock. The tick stream is picked from a fast oscillator tick or from one of two reference ticks. Each output keeps a 50% duty cycle at every ratio it supports, including the ratios of 12 and 24. Everything runs as synchronous logic on a single fabric clock, `clk_i`. Each tick input is a one-cycle enable meaning "one source edge happened here". The outputs are registered clock levels.

A global range select and a per-bank select together set each bank's divide ratio. Bank C draws from its own ratio set. The feedback divider takes its ratio from the range select and a 2-bit code. A clock-stop input parks the three banks low without cutting any high phase short, and the feedback output keeps running. An active-low master reset / output enable clears all dividers into one common state and drops the output-enable flag.

Top module: `clkdiv_bank_net`

## Requirements
- R1: Banks A and B divide the selected tick stream by 4 (select 0) or 8 (select 1) when the range select is 0, and by 8 or 16 when it is 1.
- R2: Bank C divides by 8 (select 0) or 12 (select 1) when the range select is 0, and by 16 or 24 when it is 1.
- R3: The feedback output divides by 8, 16, 12, 24 for feedback codes 2'b00, 2'b01, 2'b10, 2'b11 when the range select is 0, and by twice those values when it is 1.
- R4: With `pll_en_i`=1 the dividers count `vco_tick_i`. With `pll_en_i`=0 they count `ref0_tick_i` when `ref_sel_i`=0 and `ref1_tick_i` when `ref_sel_i`=1. Ticks from any unselected source have no effect.
- R5: For a ratio N, each output is high for the first N/2 counted ticks of a period and low for the last N/2.
- R6: Bank A drives 5 identical outputs, bank B drives 5 and bank C drives 4.
- R7: While `clk_stop_ni`=0, a bank output that is low stays low, and a bank output that is high finishes its full high phase and then stays low. The feedback output is not affected. A bank resumes only from its low state.
- R8: While `mr_oe_ni`=0, all dividers are cleared, every output is low from the next edge on, and `oe_o` is 0. `oe_o` is 1 one cycle after `mr_oe_ni` returns to 1.
- R9: After `mr_oe_ni` is released, the first counted tick drives every output that is not stopped high in the same cycle. This aligns the rising edges of all banks.
- R10: A ratio change takes effect only when the divider completes its current period. The period in progress ends with the old ratio, and the new one starts from a counter value of zero.
- R11: Outputs change only at the clock edge that samples a selected tick, mr low, or a clock-stop transition. With no tick, the feedback output holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vco_tick_i | input | 1 | Oscillator edge enable |
| ref0_tick_i | input | 1 | Reference 0 edge enable |
| ref1_tick_i | input | 1 | Reference 1 edge enable |
| ref_sel_i | input | 1 | Reference choice: 0 = ref0, 1 = ref1 |
| pll_en_i | input | 1 | 1 = count oscillator ticks, 0 = bypass to the reference |
| range_sel_i | input | 1 | Global ratio range select |
| sel_a_i | input | 1 | Bank A ratio select |
| sel_b_i | input | 1 | Bank B ratio select |
| sel_c_i | input | 1 | Bank C ratio select |
| fb_sel_i | input | 2 | Feedback ratio code |
| clk_stop_ni | input | 1 | Active-low bank clock stop |
| mr_oe_ni | input | 1 | Active-low master reset / output disable |
| qa_o | output | 5 | Bank A clocks |
| qb_o | output | 5 | Bank B clocks |
| qc_o | output | 4 | Bank C clocks |
| fb_o | output | 1 | Feedback clock |
| oe_o | output | 1 | Output enable flag |

## Verification
Every output is due in the cycle whose rising edge samples the causing input. Each tick, clear or clock-stop decision is reflected one edge later, and there is no further pipeline delay. The bench drives inputs at the falling edge. It advances its own model at the next rising edge and compares at the following falling edge, so each comparison sees exactly one edge of effect. Directed runs count how many ticks each output stays high and low after a clear and compare the counts with the ratio tables. Random runs with rare reconfiguration, stops and clears compare every output in every cycle.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int CNT_W = 6;

    typedef logic [CNT_W-1:0] ratio_t;

    // Banks A and B: base 4/8, doubled in the upper range
    function automatic ratio_t ab_ratio(input logic range_hi, input logic sel);
        ratio_t base;
        base = sel ? ratio_t'(8) : ratio_t'(4);
        return range_hi ? ratio_t'(base << 1) : base;
    endfunction

    // Bank C: base 8/12, doubled in the upper range
    function automatic ratio_t c_ratio(input logic range_hi, input logic sel);
        ratio_t base;
        base = sel ? ratio_t'(12) : ratio_t'(8);
        return range_hi ? ratio_t'(base << 1) : base;
    endfunction

    // Feedback: code bit 0 doubles, code bit 1 selects the x3 family
    function automatic ratio_t fb_ratio(input logic range_hi, input logic [1:0] code);
        ratio_t base;
        base = code[1] ? ratio_t'(12) : ratio_t'(8);
        if (code[0]) base = ratio_t'(base << 1);
        return range_hi ? ratio_t'(base << 1) : base;
    endfunction

endpackage

// File: rtl/clkdiv_src_mux.sv
module clkdiv_src_mux (
    input  logic vco_tick_i,
    input  logic ref0_tick_i,
    input  logic ref1_tick_i,
    input  logic ref_sel_i,
    input  logic pll_en_i,
    output logic tick_o
);
    logic ref_tick;

    always_comb begin
        ref_tick = ref_sel_i ? ref1_tick_i : ref0_tick_i;
        tick_o   = pll_en_i ? vco_tick_i : ref_tick;
    end
endmodule

// File: rtl/clkdiv_ratio_ctr.sv
module clkdiv_ratio_ctr #(
    parameter int CW        = 6,
    parameter int RST_RATIO = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clr_i,
    input  logic          tick_i,
    input  logic [CW-1:0] ratio_i,
    output logic          lvl_o
);
    typedef struct packed {
        logic [CW-1:0] ph;
        logic [CW-1:0] ratio;
        logic          lvl;
    } ctr_st_t;

    ctr_st_t st_d, st_q;
    logic [CW-1:0] half;

    always_comb begin
        st_d = st_q;
        half = st_q.ratio >> 1;
        if (clr_i) begin
            st_d.ph    = '0;
            st_d.ratio = ratio_i;
            st_d.lvl   = 1'b0;
        end else if (tick_i) begin
            st_d.lvl = (st_q.ph < half);
            if (st_q.ph == st_q.ratio - CW'(1)) begin
                st_d.ph    = '0;
                st_d.ratio = ratio_i;
            end else begin
                st_d.ph = st_q.ph + CW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.ph    <= '0;
            st_q.ratio <= CW'(RST_RATIO);
            st_q.lvl   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o = st_q.lvl;
endmodule

// File: rtl/clkdiv_stop_gate.sv
module clkdiv_stop_gate (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    input  logic stop_ni,
    output logic clk_o
);
    logic run_d, run_q;

    // The run flag may only move while the divided level is low
    always_comb begin
        run_d = run_q;
        if (!lvl_i) run_d = stop_ni;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) run_q <= 1'b1;
        else         run_q <= run_d;
    end

    assign clk_o = lvl_i & run_q;
endmodule

// File: rtl/clkdiv_bank_net.sv
module clkdiv_bank_net #(
    parameter int NA = 5,
    parameter int NB = 5,
    parameter int NC = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          vco_tick_i,
    input  logic          ref0_tick_i,
    input  logic          ref1_tick_i,
    input  logic          ref_sel_i,
    input  logic          pll_en_i,
    input  logic          range_sel_i,
    input  logic          sel_a_i,
    input  logic          sel_b_i,
    input  logic          sel_c_i,
    input  logic [1:0]    fb_sel_i,
    input  logic          clk_stop_ni,
    input  logic          mr_oe_ni,
    output logic [NA-1:0] qa_o,
    output logic [NB-1:0] qb_o,
    output logic [NC-1:0] qc_o,
    output logic          fb_o,
    output logic          oe_o
);
    import clkdiv_pkg::*;

    localparam int NDIV  = 4;      // A, B, C, feedback
    localparam int NBANK = NDIV - 1;
    localparam int FB_IX = NDIV - 1;

    typedef struct packed {
        logic oe;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    tick;
    logic    clr;
    ratio_t  want  [NDIV];
    logic    lvl   [NDIV];
    logic    bank_clk [NBANK];

    clkdiv_src_mux u_src (
        .vco_tick_i (vco_tick_i),
        .ref0_tick_i(ref0_tick_i),
        .ref1_tick_i(ref1_tick_i),
        .ref_sel_i  (ref_sel_i),
        .pll_en_i   (pll_en_i),
        .tick_o     (tick)
    );

    always_comb begin
        clr        = !mr_oe_ni;
        want[0]    = ab_ratio(range_sel_i, sel_a_i);
        want[1]    = ab_ratio(range_sel_i, sel_b_i);
        want[2]    = c_ratio(range_sel_i, sel_c_i);
        want[FB_IX] = fb_ratio(range_sel_i, fb_sel_i);
        st_d       = st_q;
        st_d.oe    = mr_oe_ni;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    for (genvar d = 0; d < NDIV; d++) begin : g_div
        clkdiv_ratio_ctr #(
            .CW       (CNT_W),
            .RST_RATIO(8)
        ) u_ctr (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .clr_i  (clr),
            .tick_i (tick),
            .ratio_i(want[d]),
            .lvl_o  (lvl[d])
        );
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_gate
        clkdiv_stop_gate u_gate (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .lvl_i  (lvl[b]),
            .stop_ni(clk_stop_ni),
            .clk_o  (bank_clk[b])
        );
    end

    assign qa_o = {NA{bank_clk[0]}};
    assign qb_o = {NB{bank_clk[1]}};
    assign qc_o = {NC{bank_clk[2]}};
    assign fb_o = lvl[FB_IX];
    assign oe_o = st_q.oe;
endmodule

// File: rtl/clkdiv_bank_net_chk.sv
module clkdiv_bank_net_chk #(
    parameter int NA = 5,
    parameter int NB = 5,
    parameter int NC = 4
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          vco_tick_i,
    input logic          ref0_tick_i,
    input logic          ref_sel_i,
    input logic          pll_en_i,
    input logic          clk_stop_ni,
    input logic          mr_oe_ni,
    input logic [NA-1:0] qa_o,
    input logic [NB-1:0] qb_o,
    input logic [NC-1:0] qc_o,
    input logic          fb_o,
    input logic          oe_o
);
    assert_stop_parks_a_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clk_stop_ni && qa_o[0] == 1'b0) |=> (qa_o[0] == 1'b0));

    assert_stop_parks_c_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clk_stop_ni && qc_o[0] == 1'b0) |=> (qc_o[0] == 1'b0));

    assert_clear_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mr_oe_ni |=> (!oe_o && qa_o == '0 && qb_o == '0 && qc_o == '0 && !fb_o));

    assert_oe_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mr_oe_ni |=> oe_o);

    assert_no_tick_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mr_oe_ni && pll_en_i && !vco_tick_i) |=> $stable(fb_o));

    assert_bypass_ref0_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mr_oe_ni && !pll_en_i && !ref_sel_i && !ref0_tick_i) |=> $stable(fb_o));
endmodule

bind clkdiv_bank_net clkdiv_bank_net_chk #(.NA(NA), .NB(NB), .NC(NC)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vco_tick_i (vco_tick_i),
    .ref0_tick_i(ref0_tick_i),
    .ref_sel_i  (ref_sel_i),
    .pll_en_i   (pll_en_i),
    .clk_stop_ni(clk_stop_ni),
    .mr_oe_ni   (mr_oe_ni),
    .qa_o       (qa_o),
    .qb_o       (qb_o),
    .qc_o       (qc_o),
    .fb_o       (fb_o),
    .oe_o       (oe_o)
);

// File: tb/clkdiv_bank_net_tb_top.sv
module clkdiv_bank_net_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NA = 5, NB = 5, NC = 4;
    localparam int MAX_CYCLES = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vco_tick = 0, ref0_tick = 0, ref1_tick = 0, ref_sel = 0, pll_en = 1;
    logic range_sel = 0, sel_a = 0, sel_b = 0, sel_c = 0;
    logic [1:0] fb_sel = 0;
    logic stop_n = 1, mr_n = 0;
    logic [NA-1:0] qa;
    logic [NB-1:0] qb;
    logic [NC-1:0] qc;
    logic fb, oe;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    int m_ph [4];
    int m_rat [4];
    bit m_lvl [4];
    bit m_run [3];
    bit m_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkdiv_bank_net #(.NA(NA), .NB(NB), .NC(NC)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .vco_tick_i(vco_tick), .ref0_tick_i(ref0_tick), .ref1_tick_i(ref1_tick),
        .ref_sel_i(ref_sel), .pll_en_i(pll_en), .range_sel_i(range_sel),
        .sel_a_i(sel_a), .sel_b_i(sel_b), .sel_c_i(sel_c), .fb_sel_i(fb_sel),
        .clk_stop_ni(stop_n), .mr_oe_ni(mr_n),
        .qa_o(qa), .qb_o(qb), .qc_o(qc), .fb_o(fb), .oe_o(oe)
    );

    // Ratio tables written from the requirements (R1, R2, R3)
    function automatic int exp_ratio(int d, bit rng);
        int r;
        case (d)
            0: r = sel_a ? 8 : 4;
            1: r = sel_b ? 8 : 4;
            2: r = sel_c ? 12 : 8;
            default: case (fb_sel)
                2'b00: r = 8;
                2'b01: r = 16;
                2'b10: r = 12;
                default: r = 24;
            endcase
        endcase
        return rng ? 2 * r : r;
    endfunction

    function automatic bit sel_tick();
        if (pll_en) return vco_tick;
        return ref_sel ? ref1_tick : ref0_tick;
    endfunction

    task automatic model_edge();
        bit t;
        t = sel_tick();
        for (int b = 0; b < 3; b++)
            if (!m_lvl[b]) m_run[b] = stop_n;
        for (int d = 0; d < 4; d++) begin
            if (!mr_n) begin
                m_ph[d] = 0; m_rat[d] = exp_ratio(d, range_sel); m_lvl[d] = 0;
            end else if (t) begin
                m_lvl[d] = (m_ph[d] < m_rat[d] / 2);
                if (m_ph[d] == m_rat[d] - 1) begin
                    m_ph[d] = 0; m_rat[d] = exp_ratio(d, range_sel);
                end else m_ph[d] = m_ph[d] + 1;
            end
        end
        m_oe = mr_n;
    endtask

    task automatic check(string tag, bit ok, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        logic [NA-1:0] ea;
        logic [NB-1:0] eb;
        logic [NC-1:0] ec;
        ea = {NA{m_lvl[0] & m_run[0]}};
        eb = {NB{m_lvl[1] & m_run[1]}};
        ec = {NC{m_lvl[2] & m_run[2]}};
        check(tag, qa == ea, "qa", int'(qa), int'(ea));
        check(tag, qb == eb, "qb", int'(qb), int'(eb));
        check(tag, qc == ec, "qc", int'(qc), int'(ec));
        check(tag, fb == m_lvl[3], "fb", int'(fb), int'(m_lvl[3]));
        check(tag, oe == m_oe, "oe", int'(oe), int'(m_oe));
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    function automatic bit out_of(int d);
        case (d)
            0: return qa[0];
            1: return qb[0];
            2: return qc[0];
            default: return fb;
        endcase
    endfunction

    // Clear, then count ticks high and low for divider d (R5 and ratio reqs)
    task automatic measure(int d, string tag);
        int hi, lo, half;
        vco_tick = 0; mr_n = 0; stop_n = 1; pll_en = 1;
        step(tag);
        mr_n = 1; vco_tick = 1;
        half = exp_ratio(d, range_sel) / 2;
        hi = 0; lo = 0;
        for (int k = 0; k < 200; k++) begin
            step(tag);
            if (out_of(d)) begin
                if (lo > 0) break;
                hi++;
            end else lo++;
        end
        check(tag, hi == half, "high ticks", hi, half);
        check("R5", lo == half, "low ticks", lo, half);
    endtask

    initial begin
        #(CLK_PERIOD * MAX_CYCLES);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int d = 0; d < 4; d++) begin m_ph[d] = 0; m_rat[d] = 8; m_lvl[d] = 0; end
        for (int b = 0; b < 3; b++) m_run[b] = 1;
        m_oe = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R8: held in master reset
        for (int k = 0; k < 3; k++) step("R8");
        check("R8", oe == 1'b0, "oe in reset", int'(oe), 0);

        // R9: first tick after release raises everything together
        mr_n = 1; vco_tick = 0;
        step("R9");
        check("R8", oe == 1'b1, "oe after release", int'(oe), 1);
        vco_tick = 1;
        step("R9");
        check("R9", (&qa) && (&qb) && (&qc) && fb, "all high",
              int'({qa[0], qb[0], qc[0], fb}), 4'hf);
        check("R6", qa == {NA{qa[0]}} && qc == {NC{qc[0]}}, "bank copies", int'(qa), int'({NA{qa[0]}}));

        // R1, R2, R3 with R5 duty from the ratio tables
        for (int r = 0; r < 2; r++)
            for (int s = 0; s < 2; s++) begin
                range_sel = r[0]; sel_a = s[0]; sel_b = ~s[0]; sel_c = s[0];
                measure(0, "R1");
                measure(1, "R1");
                measure(2, "R2");
            end
        for (int r = 0; r < 2; r++)
            for (int c = 0; c < 4; c++) begin
                range_sel = r[0]; fb_sel = c[1:0];
                measure(3, "R3");
            end

        // R10: ratio change mid-period finishes the old period first
        range_sel = 0; sel_a = 0; vco_tick = 0; mr_n = 0;
        step("R10");
        mr_n = 1; vco_tick = 1;
        step("R10");
        sel_a = 1;
        for (int k = 0; k < 12; k++) step("R10");

        // R7: stop while bank A high, feedback keeps running
        stop_n = 0;
        for (int k = 0; k < 40; k++) step("R7");
        check("R7", qa == '0 && qb == '0 && qc == '0, "banks parked", int'(qa), 0);
        stop_n = 1;
        for (int k = 0; k < 20; k++) step("R7");

        // R4: bypass selection, unselected ticks ignored
        pll_en = 0; ref_sel = 0;
        for (int k = 0; k < 30; k++) begin
            vco_tick = 1; ref1_tick = 1; ref0_tick = k[0];
            step("R4");
        end
        ref_sel = 1;
        for (int k = 0; k < 30; k++) begin
            vco_tick = 1; ref0_tick = 1; ref1_tick = k[1];
            step("R4");
        end

        // R11: random traffic with rare reconfiguration, stops and clears
        for (int k = 0; k < 6000; k++) begin
            vco_tick  = ($urandom % 4) != 0;
            ref0_tick = $urandom % 2;
            ref1_tick = $urandom % 2;
            if ($urandom % 50 == 0) {range_sel, sel_a, sel_b, sel_c, fb_sel} = 6'($urandom);
            if ($urandom % 80 == 0) {pll_en, ref_sel} = 2'($urandom);
            if ($urandom % 30 == 0) stop_n = ~stop_n;
            if (!mr_n) mr_n = ($urandom % 3) == 0;
            else if ($urandom % 300 == 0) mr_n = 0;
            step("R11");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule